// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Driver

This block holds one byte for each of eight digit positions and scans them onto a multiplexed LED array, one digit at a time. A host writes a data byte to a 3-bit digit address using a single-cycle write strobe. Any digit can be rewritten without touching the others. A two-bit mode input picks how every stored byte is turned into a segment pattern, and the mode is applied when the digit is shown. The choices are raw drive, a hexadecimal font, or a numeric font with six extra symbols.

The scan is a three-state machine. **ST_DRIVE** drives one digit for `ON_CYCLES` clocks. **ST_BLANK** removes all drive for `GAP_CYCLES` clocks, which prevents ghosting. **ST_HALT** is entered while shutdown is high. The transitions are:
- **T_DRIVE_DONE**: ST_DRIVE to ST_BLANK when the on-time expires.
- **T_BLANK_DONE**: ST_BLANK to ST_DRIVE on the next digit when the gap expires.
- **T_HALT**: any state to ST_HALT when shutdown is sampled high.
- **T_RESUME**: ST_HALT to ST_DRIVE on the same digit, with a fresh on-time, when shutdown is sampled low.

Writes are accepted in every state.

Top module: `segscan_top`

## Requirements
- R1: After reset, all eight stored bytes are zero, the state is ST_DRIVE on digit 0, and `dig_en` reads 8'h01.
- R2: `dig_en` never has more than one bit set. Bit k set means digit k is being driven.
- R3: Each digit is driven for exactly ON_CYCLES cycles. A gap of GAP_CYCLES cycles follows, during which `dig_en` and `seg_out` are both zero. Digits follow in ascending order and wrap from 7 to 0.
- R4: A byte on `wr_data` is stored at `wr_addr` on a clock edge where `wr_en` is high. Other entries are unchanged. The new byte is shown from the next cycle whenever that digit is driven.
- R5: With mode 2'b00 or 2'b11 (raw), `seg_out[6:0]` equals the data bits [6:0] and `seg_out[7]` equals the inverse of data bit 7.
- R6: With mode 2'b01 (hex), only data bits [3:0] are decoded, to the glyphs 0-9 and A,b,C,d,E,F. `seg_out[7]` equals data bit 7. Segment bits are bit0=a, bit1=b, through bit6=g, active high.
- R7: With mode 2'b10, codes 0-9 show numerals. Codes 10 to 15 show dash, E, H, L, P and blank. `seg_out[7]` equals data bit 7.
- R8: A change of mode alters the pattern of the digit being driven within the same cycle, with no register stage.
- R9: From the cycle after shutdown is sampled high, both output buses are zero and the scan position is held. After release, the same digit is driven again for a full on-time.
- R10: Writes made while shut down are stored and shown once the scan resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Digit address for the write |
| wr_data | input | 8 | Byte to store |
| mode | input | 2 | Decode mode: 00/11 raw, 01 hex, 10 numeric-plus-symbols |
| shutdown | input | 1 | Halts the scan and blanks the outputs |
| seg_out | output | 8 | Segments a-g in bits 0-6, decimal point in bit 7 |
| dig_en | output | 8 | One-hot digit enable |

## Verification
The bench aims at the following corner cases:
- The wrap from digit 7 to digit 0, and the exact edges of each gap. A counter that is off by one would stretch or clip the on-time, or would light segments during the gap.
- Shutdown arriving in the middle of a drive period. A design that resets the position, or that does not restart the on-time, would come back on the wrong digit or with a short period.
- Writes made during shutdown and writes made to the digit currently lit. A write path gated by shutdown would lose the data.
- A mode change in mid-period, and the decimal-point polarity in each mode. A registered decoder would show the old glyph for a cycle, and a shared decimal-point path would get the raw-mode inversion wrong.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

    localparam int DATA_W = 8;
    localparam int SEG_W  = 8;

    typedef enum logic [1:0] {
        MODE_RAW  = 2'b00,
        MODE_HEX  = 2'b01,
        MODE_ALT  = 2'b10,
        MODE_RAW2 = 2'b11
    } dec_mode_e;

    typedef enum logic [1:0] {
        ST_DRIVE = 2'b00,
        ST_BLANK = 2'b01,
        ST_HALT  = 2'b10
    } scan_st_e;

    // Glyphs are ordered g..a (bit6..bit0), active high.
    function automatic logic [6:0] hex_glyph(input logic [3:0] n);
        logic [6:0] g;
        unique case (n)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

    function automatic logic [6:0] alt_glyph(input logic [3:0] n);
        logic [6:0] g;
        unique case (n)
            4'hA: g = 7'h40;  // dash
            4'hB: g = 7'h79;  // E
            4'hC: g = 7'h76;  // H
            4'hD: g = 7'h38;  // L
            4'hE: g = 7'h73;  // P
            4'hF: g = 7'h00;  // blank
            default: g = hex_glyph(n);
        endcase
        return g;
    endfunction

endpackage

// File: rtl/segscan_mem.sv
module segscan_mem #(
    parameter int DIGITS = 8,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(DIGITS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(DIGITS)-1:0] rd_idx,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int ADDR_W = $clog2(DIGITS);

    logic [DATA_W-1:0] entry [DIGITS];

    for (genvar g = 0; g < DIGITS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                entry[g] <= wr_data;
            end
        end
    end

    assign rd_data = entry[rd_idx];

endmodule

// File: rtl/segscan_decode.sv
module segscan_decode
    import segscan_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] raw,
    output logic [SEG_W-1:0]  seg
);
    dec_mode_e md;
    assign md = dec_mode_e'(mode);

    always_comb begin
        unique case (md)
            MODE_HEX: seg = {raw[7], hex_glyph(raw[3:0])};
            MODE_ALT: seg = {raw[7], alt_glyph(raw[3:0])};
            MODE_RAW,
            MODE_RAW2: seg = {~raw[7], raw[6:0]};
            default:  seg = {~raw[7], raw[6:0]};
        endcase
    end

endmodule

// File: rtl/segscan_seq.sv
module segscan_seq
    import segscan_pkg::*;
#(
    parameter int DIGITS     = 8,
    parameter int ON_CYCLES  = 16,
    parameter int GAP_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      halt,
    output logic                      drive_on,
    output logic [$clog2(DIGITS)-1:0] digit_idx
);
    localparam int ADDR_W  = $clog2(DIGITS);
    localparam int CNT_MAX = (ON_CYCLES > GAP_CYCLES) ? ON_CYCLES : GAP_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  ON_LAST  = CNT_W'(ON_CYCLES - 1);
    localparam logic [CNT_W-1:0]  GAP_LAST = CNT_W'(GAP_CYCLES - 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(DIGITS - 1);

    scan_st_e          st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [ADDR_W-1:0] idx, idx_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_DRIVE;
            cnt <= '0;
            idx <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            idx <= idx_n;
        end
    end

    // Transitions: T_HALT, T_RESUME, T_DRIVE_DONE, T_BLANK_DONE
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        idx_n = idx;
        unique case (st)
            ST_DRIVE: begin
                if (halt) begin
                    st_n = ST_HALT;
                end else if (cnt == ON_LAST) begin
                    st_n  = ST_BLANK;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_BLANK: begin
                if (halt) begin
                    st_n = ST_HALT;
                end else if (cnt == GAP_LAST) begin
                    st_n  = ST_DRIVE;
                    cnt_n = '0;
                    idx_n = (idx == IDX_LAST) ? '0 : idx + 1'b1;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_HALT: begin
                if (!halt) begin
                    st_n  = ST_DRIVE;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_HALT;
                cnt_n = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        drive_on  = (st == ST_DRIVE);
        digit_idx = idx;
    end

endmodule

// File: rtl/segscan_top.sv
module segscan_top
    import segscan_pkg::*;
#(
    parameter int DIGITS     = 8,
    parameter int ON_CYCLES  = 16,
    parameter int GAP_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(DIGITS)-1:0] wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [1:0]                mode,
    input  logic                      shutdown,
    output logic [7:0]                seg_out,
    output logic [DIGITS-1:0]         dig_en
);
    localparam int ADDR_W = $clog2(DIGITS);

    logic              drive_on;
    logic [ADDR_W-1:0] digit_idx;
    logic [DATA_W-1:0] cur_raw;
    logic [SEG_W-1:0]  cur_seg;

    segscan_seq #(
        .DIGITS(DIGITS), .ON_CYCLES(ON_CYCLES), .GAP_CYCLES(GAP_CYCLES)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .halt(shutdown),
        .drive_on(drive_on), .digit_idx(digit_idx)
    );

    segscan_mem #(.DIGITS(DIGITS), .DATA_W(DATA_W)) mem_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_idx(digit_idx), .rd_data(cur_raw)
    );

    segscan_decode dec_i (.mode(mode), .raw(cur_raw), .seg(cur_seg));

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign dig_en[g] = drive_on && (digit_idx == ADDR_W'(g));
    end

    assign seg_out = drive_on ? cur_seg : '0;

endmodule

// File: rtl/segscan_chk.sv
module segscan_chk #(
    parameter int DIGITS    = 8,
    parameter int ON_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shutdown,
    input logic [7:0]        seg_out,
    input logic [DIGITS-1:0] dig_en
);
    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_cnt <= 0;
        else if (dig_en != '0)  run_cnt <= run_cnt + 1;
        else                    run_cnt <= 0;
    end

    // R2
    onehot_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));

    // R3
    gap_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en == '0) |-> (seg_out == '0));

    // R3
    digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0 && $past(dig_en) != '0) |-> (dig_en == $past(dig_en)));

    // R3
    on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0) |-> (run_cnt < ON_CYCLES));

    // R9
    halt_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (dig_en == '0 && seg_out == '0));

endmodule

bind segscan_top segscan_chk #(.DIGITS(DIGITS), .ON_CYCLES(ON_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown),
    .seg_out(seg_out), .dig_en(dig_en)
);

// File: tb/segscan_tb.sv
module segscan_top_tb_top;
    localparam int ON  = 16;
    localparam int GAP = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] mode = 0;
    logic       shutdown = 0;
    logic [7:0] seg_out;
    logic [7:0] dig_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    segscan_top #(.DIGITS(8), .ON_CYCLES(ON), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .shutdown(shutdown),
        .seg_out(seg_out), .dig_en(dig_en)
    );

    function automatic logic [6:0] font_hex(int n);
        case (n)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
            12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    function automatic logic [6:0] font_alt(int n);
        case (n)
            10: return 7'h40; 11: return 7'h79; 12: return 7'h76;
            13: return 7'h38; 14: return 7'h73; 15: return 7'h00;
            default: return font_hex(n);
        endcase
    endfunction

    function automatic logic [7:0] exp_seg(logic [1:0] md, logic [7:0] d);
        case (md)
            2'b01:   return {d[7], font_hex(int'(d[3:0]))};
            2'b10:   return {d[7], font_alt(int'(d[3:0]))};
            default: return {~d[7], d[6:0]};
        endcase
    endfunction

    // Behavioural reference: 0 halted, 1 driving, 2 gap
    int m_st = 1;
    int m_idx = 0;
    int m_cnt = 0;
    logic [7:0] m_mem [8];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 1; m_idx = 0; m_cnt = 0;
            for (int i = 0; i < 8; i++) m_mem[i] = 8'h00;
        end else begin
            if (wr_en) m_mem[wr_addr] = wr_data;
            if (shutdown) m_st = 0;
            else if (m_st == 0) begin m_st = 1; m_cnt = 0; end
            else if (m_st == 1) begin
                if (m_cnt == ON - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
            end else begin
                if (m_cnt == GAP - 1) begin m_st = 1; m_cnt = 0; m_idx = (m_idx + 1) % 8; end
                else m_cnt++;
            end
        end
        if (cyc == 150000 && !done) begin
            failures++; checks++;
            $display("FAIL watchdog: run hung act=%0d exp=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] e_dig, e_seg;
            string tag;
            e_dig = (m_st == 1) ? 8'(1 << m_idx) : 8'h00;
            e_seg = (m_st == 1) ? exp_seg(mode, m_mem[m_idx]) : 8'h00;
            tag = (m_st == 0) ? "R9" : (m_st == 2) ? "R3" :
                  (mode == 2'b01) ? "R6" : (mode == 2'b10) ? "R7" : "R5";
            check("R3 dig_en", dig_en, e_dig);
            check(tag, seg_out, e_seg);
            check("R2 onehot", 8'($countones(dig_en) <= 1), 8'd1);
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = 3'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic wait_digit(int a);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (dig_en == 8'(1 << a)) break;
        end
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset dig_en", dig_en, 8'h01);
        check("R1 reset seg", seg_out, 8'h80);
        tick(170);

        // R5 raw mode, both raw codes
        for (int i = 0; i < 8; i++) wr(i, 8'(8'h81 + i * 8'h13));
        tick(340);
        mode = 2'b11;
        tick(170);

        // R6 hex mode over all sixteen codes
        mode = 2'b01;
        for (int i = 0; i < 8; i++) wr(i, 8'(i | ((i & 1) << 7)));
        tick(170);
        for (int i = 0; i < 8; i++) wr(i, 8'(8 + i));
        tick(170);

        // R7 alternate font over all sixteen codes
        mode = 2'b10;
        tick(170);
        for (int i = 0; i < 8; i++) wr(i, 8'(i | 8'h80));
        tick(170);

        // R8 mode change mid-period
        wait_digit(3);
        @(posedge clk); #1;
        mode = 2'b00;
        #1;
        check("R8 mode switch", seg_out, {~m_mem[3][7], m_mem[3][6:0]});
        tick(20);

        // R4 write to the digit currently lit
        wait_digit(6);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = 3'd6; wr_data = 8'h5A;
        @(posedge clk); #1;
        wr_en = 0;
        check("R4 write visible", seg_out, 8'hDA);
        tick(170);

        // R9/R10 shutdown mid-period, writes while halted
        wait_digit(5);
        tick(3);
        shutdown = 1;
        tick(2);
        check("R9 halted dig", dig_en, 8'h00);
        check("R9 halted seg", seg_out, 8'h00);
        wr(5, 8'h3C);
        wr(2, 8'hC3);
        tick(20);
        shutdown = 0;
        tick(1);
        check("R9 resume digit", dig_en, 8'h20);
        check("R10 write during halt", seg_out, 8'hBC);
        tick(ON - 1);
        check("R9 full on-time", dig_en, 8'h20);
        wait_digit(2);
        check("R10 second write", seg_out, 8'h43);
        tick(200);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule